// File: doc/BRIEF.md
# Decoupling FIFO Between Pipeline Units

This block sits between a producing pipeline and a consuming unit that share one clock. It holds up to `DEPTH` items of `WIDTH` bits each. The producer sees only whether the queue has a free slot. The consumer sees only whether an item is waiting and which item is at the head. The control path is cut between the two sides: the ready signal returned to the producer comes from a registered occupancy flag, so it never depends on the consumer's ready in the same cycle.

When `DEPTH` is two or more, the queue can take one item and release one item in every cycle, so a steady stream passes at full rate. When `DEPTH` is one, the single slot is either full or empty. Intake and release then take turns, and the two sides never transfer in the same cycle. A synchronous active-high reset empties the queue.

Top module: `decouple_fifo`

## Requirements
- R1: One clock edge after `rst` is high, `out_valid` is 0 and `in_ready` is 1. Any items held before the reset are discarded.
- R2: `in_ready` is 1 exactly when fewer than `DEPTH` items are held. It comes from registered state only, so a change of `out_ready` within a cycle leaves `in_ready` unchanged in that cycle.
- R3: An offer made while `in_ready` is 0 is not stored. The item count never exceeds `DEPTH`.
- R4: `out_valid` is 1 exactly when at least one item is held.
- R5: Items leave in the order they were accepted, and `out_data` always shows the oldest held item.
- R6: Asserting `out_ready` while `out_valid` is 0 has no effect on the contents.
- R7: With `DEPTH` of at least 2, an accept and a release in the same cycle leave the count unchanged. A partly filled queue with both sides always willing moves one item per cycle in each direction.
- R8: With `DEPTH` equal to 1, an accept and a release never happen in the same cycle. With both sides always willing, transfers alternate, giving one item every two cycles.
- R9: While `out_valid` is 1 and `out_ready` is 0, the next cycle still shows `out_valid` at 1 and the same `out_data`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for both sides |
| rst | input | 1 | Synchronous active-high reset; empties the queue |
| in_valid | input | 1 | Producer offers `in_data` |
| in_ready | output | 1 | A free slot exists (registered) |
| in_data | input | WIDTH | Item offered by the producer |
| out_valid | output | 1 | An item is waiting (registered) |
| out_ready | input | 1 | Consumer takes the head item |
| out_data | output | WIDTH | Oldest held item |

## Verification
On every cycle, the assertions compare both ready/valid flags against an occupancy count rebuilt from the observed handshakes. They also check that the count stays bounded, that the head item is held while the consumer stalls, that reset leaves the queue empty, and, for the single-slot variant, that the two sides never transfer in the same cycle. Some behaviour only the bench scenarios can show. These are ordering and contents against a reference queue, offers rejected while full leaving no trace in the output stream, releases requested while empty creating no phantom items, the measured rate in each depth configuration, and `in_ready` staying put when `out_ready` toggles mid-cycle.

// File: rtl/decouple_fifo_pkg.sv
package decouple_fifo_pkg;

  // Index width for a ring of the given size (at least one bit).
  function automatic int slot_index_width(input int depth);
    return (depth > 1) ? $clog2(depth) : 1;
  endfunction

  // Width able to hold the values 0..depth.
  function automatic int level_width(input int depth);
    return $clog2(depth + 1);
  endfunction

  typedef struct packed {
    logic full;
    logic empty;
  } occ_flags_t;

endpackage

// File: rtl/dfifo_ptr.sv
module dfifo_ptr #(
  parameter int DEPTH = 4,
  parameter int PW    = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          adv,
  output logic [PW-1:0] ptr
);

  localparam logic [PW-1:0] LAST = PW'(DEPTH - 1);

  logic [PW-1:0] ptr_q;

  generate
    if (DEPTH == 1) begin : g_fixed
      // A single slot is always addressed by zero.
      logic unused_adv;
      assign unused_adv = adv;
      always_ff @(posedge clk) begin
        if (rst) ptr_q <= '0;
        else     ptr_q <= '0;
      end
    end else begin : g_ring
      always_ff @(posedge clk) begin
        if (rst) begin
          ptr_q <= '0;
        end else if (adv) begin
          if (ptr_q == LAST) ptr_q <= '0;
          else               ptr_q <= ptr_q + 1'b1;
        end
      end
    end
  endgenerate

  assign ptr = ptr_q;

endmodule

// File: rtl/dfifo_ctrl.sv
module dfifo_ctrl
  import decouple_fifo_pkg::*;
#(
  parameter int DEPTH = 4,
  parameter int PW    = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          in_valid,
  input  logic          out_ready,
  output logic          push,
  output logic          pop,
  output logic [PW-1:0] wr_ptr,
  output logic [PW-1:0] rd_ptr,
  output occ_flags_t    flags
);

  localparam int CW = level_width(DEPTH);
  localparam logic [CW-1:0] FULL_LEVEL = CW'(DEPTH);

  logic [CW-1:0] level_q;
  logic [CW-1:0] level_nxt;
  occ_flags_t    flags_q;

  // Acceptance uses only the registered flags of this side.
  assign push = in_valid  & ~flags_q.full;
  assign pop  = out_ready & ~flags_q.empty;

  always_comb begin
    level_nxt = level_q;
    unique case ({push, pop})
      2'b10:   level_nxt = level_q + 1'b1;
      2'b01:   level_nxt = level_q - 1'b1;
      default: level_nxt = level_q;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      level_q       <= '0;
      flags_q.full  <= 1'b0;
      flags_q.empty <= 1'b1;
    end else begin
      level_q       <= level_nxt;
      flags_q.full  <= (level_nxt == FULL_LEVEL);
      flags_q.empty <= (level_nxt == '0);
    end
  end

  dfifo_ptr #(.DEPTH(DEPTH), .PW(PW)) u_wr_ptr (
    .clk (clk),
    .rst (rst),
    .adv (push),
    .ptr (wr_ptr)
  );

  dfifo_ptr #(.DEPTH(DEPTH), .PW(PW)) u_rd_ptr (
    .clk (clk),
    .rst (rst),
    .adv (pop),
    .ptr (rd_ptr)
  );

  assign flags = flags_q;

endmodule

// File: rtl/dfifo_store.sv
module dfifo_store #(
  parameter int WIDTH = 16,
  parameter int DEPTH = 4,
  parameter int PW    = 2
) (
  input  logic             clk,
  input  logic             we,
  input  logic [PW-1:0]    waddr,
  input  logic [WIDTH-1:0] wdata,
  input  logic [PW-1:0]    raddr,
  output logic [WIDTH-1:0] rdata
);

  generate
    if (DEPTH == 1) begin : g_single
      logic [WIDTH-1:0] slot_q;
      logic             unused_addr;
      assign unused_addr = ^{waddr, raddr};
      always_ff @(posedge clk) begin
        if (we) slot_q <= wdata;
      end
      assign rdata = slot_q;
    end else begin : g_array
      // Write-synchronous, read-asynchronous: maps to distributed RAM.
      logic [WIDTH-1:0] mem [DEPTH];
      always_ff @(posedge clk) begin
        if (we) mem[waddr] <= wdata;
      end
      assign rdata = mem[raddr];
    end
  endgenerate

endmodule

// File: rtl/decouple_fifo.sv
module decouple_fifo
  import decouple_fifo_pkg::*;
#(
  parameter int WIDTH = 16,
  parameter int DEPTH = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [WIDTH-1:0] in_data,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [WIDTH-1:0] out_data
);

  localparam int PW = slot_index_width(DEPTH);

  logic          push;
  logic          pop;
  logic [PW-1:0] wr_ptr;
  logic [PW-1:0] rd_ptr;
  occ_flags_t    flags;

  dfifo_ctrl #(.DEPTH(DEPTH), .PW(PW)) u_ctrl (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .out_ready (out_ready),
    .push      (push),
    .pop       (pop),
    .wr_ptr    (wr_ptr),
    .rd_ptr    (rd_ptr),
    .flags     (flags)
  );

  dfifo_store #(.WIDTH(WIDTH), .DEPTH(DEPTH), .PW(PW)) u_store (
    .clk   (clk),
    .we    (push),
    .waddr (wr_ptr),
    .wdata (in_data),
    .raddr (rd_ptr),
    .rdata (out_data)
  );

  logic unused_pop;
  assign unused_pop = pop;

  assign in_ready  = ~flags.full;
  assign out_valid = ~flags.empty;

endmodule

// File: rtl/decouple_fifo_chk.sv
module decouple_fifo_chk #(
  parameter int WIDTH = 16,
  parameter int DEPTH = 4
) (
  input logic             clk,
  input logic             rst,
  input logic             in_valid,
  input logic             in_ready,
  input logic [WIDTH-1:0] in_data,
  input logic             out_valid,
  input logic             out_ready,
  input logic [WIDTH-1:0] out_data
);

  localparam int CW = $clog2(DEPTH + 2);
  localparam logic [CW-1:0] CAP = CW'(DEPTH);

  logic          in_fire;
  logic          out_fire;
  logic [CW-1:0] occ;
  logic          unused_data;

  assign in_fire     = in_valid & in_ready;
  assign out_fire    = out_valid & out_ready;
  assign unused_data = ^in_data;

  always_ff @(posedge clk) begin
    if (rst) begin
      occ <= '0;
    end else if (in_fire && !out_fire) begin
      occ <= occ + 1'b1;
    end else if (out_fire && !in_fire) begin
      occ <= occ - 1'b1;
    end
  end

  AST_RESET_EMPTY: assert property (@(posedge clk) rst |=> (!out_valid && in_ready)); // R1
  AST_READY_LEVEL: assert property (@(posedge clk) disable iff (rst) in_ready == (occ != CAP)); // R2
  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst) occ <= CAP); // R3
  AST_VALID_LEVEL: assert property (@(posedge clk) disable iff (rst) out_valid == (occ != '0)); // R4
  AST_HEAD_HOLD:   assert property (@(posedge clk) disable iff (rst)
                     (out_valid && !out_ready) |=> (out_valid && $stable(out_data))); // R9

  generate
    if (DEPTH == 1) begin : g_one
      AST_NO_OVERLAP: assert property (@(posedge clk) disable iff (rst) !(in_fire && out_fire)); // R8
    end else begin : g_many
      AST_ROOM_READY: assert property (@(posedge clk) disable iff (rst) (occ < CAP) |-> in_ready); // R7
    end
  endgenerate

endmodule

bind decouple_fifo decouple_fifo_chk #(.WIDTH(WIDTH), .DEPTH(DEPTH)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .in_valid  (in_valid),
  .in_ready  (in_ready),
  .in_data   (in_data),
  .out_valid (out_valid),
  .out_ready (out_ready),
  .out_data  (out_data)
);

// File: tb/test_decouple_fifo.sv
module test_decouple_fifo;

  localparam int W = 16;
  localparam int D = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #2 clk = ~clk;

  logic         in_valid = 1'b0, out_ready = 1'b0;
  logic [W-1:0] in_data = '0;
  logic         in_ready, out_valid;
  logic [W-1:0] out_data;

  logic         s_valid = 1'b0, s_oready = 1'b0;
  logic [W-1:0] s_data = '0;
  logic         s_ready, s_ovalid;
  logic [W-1:0] s_odata;

  decouple_fifo #(.WIDTH(W), .DEPTH(D)) i_decouple_fifo (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data));

  decouple_fifo #(.WIDTH(W), .DEPTH(1)) i_decouple_fifo_d1 (
    .clk(clk), .rst(rst), .in_valid(s_valid), .in_ready(s_ready), .in_data(s_data),
    .out_valid(s_ovalid), .out_ready(s_oready), .out_data(s_odata));

  int checks = 0;
  int fails  = 0;
  bit done   = 0;
  logic [W-1:0] mq[$];
  int n_push = 0, n_pop = 0;
  logic         prev_hold = 1'b0;
  logic [W-1:0] prev_data = '0;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h t=%0t", req, act, exp, $time);
    end
  endtask

  function automatic logic exp_ready(input int size);
    return size < D;
  endfunction

  function automatic logic exp_valid(input int size);
    return size > 0;
  endfunction

  // Called at a falling edge: check, drive, advance one cycle, update model.
  task automatic step(input logic ev, input logic dr, input logic [W-1:0] d);
    logic er0;
    logic pu, po;
    chk("R4 out_valid", out_valid, exp_valid(mq.size()));
    chk("R2 in_ready", in_ready, exp_ready(mq.size()));
    if (mq.size() > 0) chk("R5 head data", out_data, mq[0]);
    if (prev_hold) chk("R9 held data", out_data, prev_data);
    er0 = in_ready;
    in_valid = ev; out_ready = dr; in_data = d;
    #1;
    out_ready = ~dr;
    #0.1;
    chk("R2 ready independent of out_ready", in_ready, er0);
    out_ready = dr;
    pu = ev && exp_ready(mq.size());
    po = dr && exp_valid(mq.size());
    prev_hold = exp_valid(mq.size()) && !dr;
    prev_data = out_data;
    @(posedge clk);
    if (po) begin void'(mq.pop_front()); n_pop++; end
    if (pu) begin mq.push_back(d); n_push++; end
    @(negedge clk);
  endtask

  task automatic do_reset();
    rst = 1'b1; in_valid = 0; out_ready = 0; s_valid = 0; s_oready = 0;
    @(posedge clk); @(negedge clk);
    rst = 1'b0;
    mq.delete();
    prev_hold = 1'b0;
    chk("R1 out_valid after reset", out_valid, 1'b0);
    chk("R1 in_ready after reset", in_ready, 1'b1);
    chk("R1 single-slot out_valid after reset", s_ovalid, 1'b0);
  endtask

  initial begin
    #(4 * 200000);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd5150));
    @(negedge clk); @(negedge clk);
    do_reset();

    // R3: fill, then offer while full; tagged items must never appear.
    for (int i = 0; i < D; i++) step(1'b1, 1'b0, W'(16'h1000 + i));
    chk("R3 in_ready when full", in_ready, 1'b0);
    for (int i = 0; i < 3; i++) step(1'b1, 1'b0, 16'hDEAD);
    chk("R3 count stays at capacity", in_ready, 1'b0);
    for (int i = 0; i < D; i++) begin
      chk("R3 drained item not rejected tag", (out_data == 16'hDEAD), 1'b0);
      step(1'b0, 1'b1, '0);
    end
    chk("R4 empty after drain", out_valid, 1'b0);

    // R6: release requests while empty create nothing.
    for (int i = 0; i < 3; i++) step(1'b0, 1'b1, '0);
    chk("R6 still empty", out_valid, 1'b0);
    step(1'b1, 1'b0, 16'h0ACE);
    chk("R6 first item intact", out_data, 16'h0ACE);

    // R1: reset with items held.
    step(1'b1, 1'b0, 16'h0BEE);
    do_reset();

    // R7: two items held, both sides always willing.
    step(1'b1, 1'b0, 16'h2000);
    step(1'b1, 1'b0, 16'h2001);
    n_push = 0; n_pop = 0;
    for (int i = 0; i < 20; i++) step(1'b1, 1'b1, W'(16'h2100 + i));
    chk("R7 accepts in 20 cycles", n_push, 20);
    chk("R7 releases in 20 cycles", n_pop, 20);
    chk("R7 level unchanged", mq.size(), 2);

    // Random mixes with different fill pressure (R5, R9 and flags each cycle).
    for (int ph = 0; ph < 3; ph++) begin
      int pin  = (ph == 0) ? 75 : (ph == 1) ? 30 : 50;
      int pout = (ph == 0) ? 30 : (ph == 1) ? 75 : 50;
      for (int i = 0; i < 400; i++)
        step(($urandom % 100) < pin, ($urandom % 100) < pout, W'($urandom));
    end

    // R8: single slot with both sides always willing.
    do_reset();
    begin
      int ins = 0, outs = 0, both = 0;
      logic [W-1:0] next_out = 16'h3000;
      logic [W-1:0] next_in  = 16'h3000;
      s_valid = 1'b1; s_oready = 1'b1; s_data = next_in;
      for (int i = 0; i < 20; i++) begin
        logic fi, fo;
        #0.5;
        fi = s_valid && s_ready;
        fo = s_ovalid && s_oready;
        if (fo) begin
          chk("R8 single-slot order", s_odata, next_out);
          next_out++;
        end
        if (fi && fo) both++;
        if (fi) ins++;
        if (fo) outs++;
        @(posedge clk);
        @(negedge clk);
        if (fi) begin next_in++; s_data = next_in; end
      end
      s_valid = 1'b0; s_oready = 1'b0;
      chk("R8 no overlapping transfers", both, 0);
      chk("R8 accepts in 20 cycles", ins, 10);
      chk("R8 releases in 20 cycles", outs, 10);
    end

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule